// File: doc/BRIEF.md
# Stalling Memory-Mapped FIFO

This block is a single-clock first-in first-out buffer whose input and output each appear as a memory-mapped slave. A master pushes 32-bit words by asserting `wr_write` on the write slave. Another master pops words by asserting `rd_read` on the read slave. Flow control uses the waitrequest line of each slave. A write issued while the buffer is full is held in place, and so is a read issued while the buffer is empty. Each transfer completes on the first cycle its waitrequest is low.

The read slave has zero latency. The word at the head of the buffer is driven on `rd_readdata` in the same cycle the read is accepted. A build-time switch turns stalling off. In that mode both waitrequest lines stay low, a write into a full buffer is dropped, and a read from an empty buffer returns the last word popped without moving anything.

A second switch adds a status group. It reports the fill level and two threshold flags, almost full and almost empty. The thresholds are set by parameters. When the status group is disabled, its outputs are tied to zero. The depth is a power of two. Full and empty are resolved with read and write pointers that each carry one extra wrap bit.

Top module: `mm_fifo`

## Requirements
- R1: A write is accepted on a rising edge where `wr_write` is high and `wr_waitrequest` is low. Accepted words leave the read slave in the order they were accepted.
- R2: With stalling enabled, `wr_waitrequest` is high in every cycle the buffer holds DEPTH words and low otherwise.
- R3: With stalling enabled, `rd_waitrequest` is high in every cycle the buffer holds no word, and low as soon as it holds at least one.
- R4: In any cycle `rd_waitrequest` is low and the buffer is non-empty, `rd_readdata` carries the oldest stored word. A read accepted at that edge removes it.
- R5: With stalling enabled, a read and a write issued together on a full buffer are handled as follows. The read completes and the write stalls. In the next cycle the write is accepted and the level returns to DEPTH.
- R6: With stalling enabled, a read and a write issued together on an empty buffer are handled as follows. The write completes and the read stalls. In the next cycle the read returns the written word.
- R7: `fill_level` equals the number of stored words, from 0 up to DEPTH inclusive. It changes by +1 per accepted write and by -1 per accepted read.
- R8: `almost_full` is high exactly when the level is at least AF_LEVEL. `almost_empty` is high exactly when the level is at most AE_LEVEL.
- R9: With stalling disabled, both waitrequest outputs stay low. A write into a full buffer is dropped. A read from an empty buffer returns the last word popped (0 after reset), and the level is unchanged.
- R10: After reset the buffer is empty, `fill_level` is 0, and `rd_readdata` is 0.
- R11: With the status group disabled, `fill_level`, `almost_full` and `almost_empty` stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| wr_write | input | 1 | Write request from the write master |
| wr_writedata | input | 32 | Word to push |
| wr_waitrequest | output | 1 | Write stall |
| rd_read | input | 1 | Read request from the read master |
| rd_readdata | output | 32 | Head word, valid in the cycle the read is accepted |
| rd_waitrequest | output | 1 | Read stall |
| fill_level | output | DEPTH_LOG2+1 | Number of stored words |
| almost_full | output | 1 | Level at or above AF_LEVEL |
| almost_empty | output | 1 | Level at or below AE_LEVEL |

## Verification
The assertions rely on these input properties:
- Reset is applied before the first transfer.
- `wr_write` and `rd_read` are never X during operation.
- A master that sees waitrequest high keeps its request and data steady until the transfer completes.

The stimulus meets these by changing inputs only on falling edges, starting from a full reset. It also drives two instances, one with stalling and one without, from the same request sequence. Directed phases push each buffer past full and drain it past empty, including cycles where a read and a write meet at both limits. These are followed by a long mixed run with biased request rates.

// File: rtl/mmf_pkg.sv
package mmf_pkg;

    localparam int unsigned WORD_W = 32;

    typedef logic [WORD_W-1:0] word_t;

    // Transfers completed at the coming edge
    typedef struct packed {
        logic wr_ok;
        logic rd_ok;
    } xfer_t;

    function automatic logic lvl_at_least(int unsigned lvl, int unsigned thr);
        return lvl >= thr;
    endfunction

    function automatic logic lvl_at_most(int unsigned lvl, int unsigned thr);
        return lvl <= thr;
    endfunction

endpackage

// File: rtl/mmf_ptr.sv
module mmf_ptr #(
    parameter int unsigned AW = 3
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        adv,
    output logic [AW:0] ptr
);
    // Index bits plus one wrap bit
    always_ff @(posedge clk) begin
        if (rst)      ptr <= '0;
        else if (adv) ptr <= ptr + 1'b1;
    end
endmodule

// File: rtl/mmf_store.sv
module mmf_store
    import mmf_pkg::*;
#(
    parameter int unsigned AW = 3
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  word_t         wdata,
    input  logic [AW-1:0] raddr,
    output word_t         rdata
);
    localparam int unsigned DEPTH = 1 << AW;

    word_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    // Combinational read gives zero read latency
    assign rdata = mem[raddr];
endmodule

// File: rtl/mmf_status.sv
module mmf_status
    import mmf_pkg::*;
#(
    parameter int unsigned LVL_W     = 4,
    parameter bit          ENABLE    = 1'b1,
    parameter int unsigned AF_LEVEL  = 6,
    parameter int unsigned AE_LEVEL  = 2
) (
    input  logic [LVL_W-1:0] level,
    output logic [LVL_W-1:0] fill_level,
    output logic             almost_full,
    output logic             almost_empty
);
    generate
        if (ENABLE) begin : g_on
            assign fill_level   = level;
            assign almost_full  = lvl_at_least(int'(level), AF_LEVEL);
            assign almost_empty = lvl_at_most(int'(level), AE_LEVEL);
        end else begin : g_off
            assign fill_level   = '0;
            assign almost_full  = 1'b0;
            assign almost_empty = 1'b0;
        end
    endgenerate
endmodule

// File: rtl/mm_fifo.sv
module mm_fifo
    import mmf_pkg::*;
#(
    parameter int unsigned DEPTH_LOG2   = 3,
    parameter bit          BACKPRESSURE = 1'b1,
    parameter bit          STATUS_EN    = 1'b1,
    parameter int unsigned AF_LEVEL     = 6,
    parameter int unsigned AE_LEVEL     = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_write,
    input  logic [31:0]           wr_writedata,
    output logic                  wr_waitrequest,
    input  logic                  rd_read,
    output logic [31:0]           rd_readdata,
    output logic                  rd_waitrequest,
    output logic [DEPTH_LOG2:0]   fill_level,
    output logic                  almost_full,
    output logic                  almost_empty
);
    localparam int unsigned AW    = DEPTH_LOG2;
    localparam int unsigned LVL_W = AW + 1;
    localparam int unsigned DEPTH = 1 << AW;

    logic [AW:0]      wptr, rptr;
    logic [LVL_W-1:0] level;
    logic             is_full, is_empty;
    word_t            head, last_q;
    xfer_t            xf;

    assign level    = wptr - rptr;
    assign is_full  = (wptr[AW] != rptr[AW]) && (wptr[AW-1:0] == rptr[AW-1:0]);
    assign is_empty = (wptr == rptr);

    generate
        if (BACKPRESSURE) begin : g_stall
            assign wr_waitrequest = is_full;
            assign rd_waitrequest = is_empty;
        end else begin : g_drop
            assign wr_waitrequest = 1'b0;
            assign rd_waitrequest = 1'b0;
        end
    endgenerate

    // A full buffer never takes a write, even beside a read in the same cycle
    always_comb begin
        xf.wr_ok = wr_write && !wr_waitrequest && !is_full;
        xf.rd_ok = rd_read  && !rd_waitrequest && !is_empty;
    end

    mmf_ptr #(.AW(AW)) u_wptr (.clk(clk), .rst(rst), .adv(xf.wr_ok), .ptr(wptr));
    mmf_ptr #(.AW(AW)) u_rptr (.clk(clk), .rst(rst), .adv(xf.rd_ok), .ptr(rptr));

    mmf_store #(.AW(AW)) u_store (
        .clk   (clk),
        .we    (xf.wr_ok),
        .waddr (wptr[AW-1:0]),
        .wdata (wr_writedata),
        .raddr (rptr[AW-1:0]),
        .rdata (head)
    );

    always_ff @(posedge clk) begin
        if (rst)           last_q <= '0;
        else if (xf.rd_ok) last_q <= head;
    end

    assign rd_readdata = is_empty ? last_q : head;

    mmf_status #(
        .LVL_W    (LVL_W),
        .ENABLE   (STATUS_EN),
        .AF_LEVEL (AF_LEVEL),
        .AE_LEVEL (AE_LEVEL)
    ) u_status (
        .level        (level),
        .fill_level   (fill_level),
        .almost_full  (almost_full),
        .almost_empty (almost_empty)
    );

    // ---------------- assertions ----------------
    assert_level_bound_R7: assert property (@(posedge clk) disable iff (rst)
        level <= LVL_W'(DEPTH));

    assert_level_step_R7: assert property (@(posedge clk) disable iff (rst)
        !rst |=> level == $past(level) + LVL_W'($past(xf.wr_ok)) - LVL_W'($past(xf.rd_ok)));

    assert_reset_state_R10: assert property (@(posedge clk)
        rst |=> (level == '0) && (rd_readdata == '0));

    generate
        if (BACKPRESSURE) begin : g_chk_stall
            assert_no_overflow_R2: assert property (@(posedge clk) disable iff (rst)
                (level == LVL_W'(DEPTH)) |-> wr_waitrequest);
            assert_no_underflow_R3: assert property (@(posedge clk) disable iff (rst)
                (level == '0) |-> rd_waitrequest);
            assert_full_meet_R5: assert property (@(posedge clk) disable iff (rst)
                (level == LVL_W'(DEPTH) && wr_write && rd_read) |=> !wr_waitrequest);
        end else begin : g_chk_drop
            assert_full_drop_R9: assert property (@(posedge clk) disable iff (rst)
                (level == LVL_W'(DEPTH) && wr_write && !rd_read) |=> (level == LVL_W'(DEPTH)) && $stable(wptr));
            assert_empty_hold_R9: assert property (@(posedge clk) disable iff (rst)
                (level == '0 && rd_read && !wr_write) |=> $stable(rd_readdata) && (level == '0));
        end
    endgenerate
endmodule

// File: tb/test_mm_fifo.sv
module test_mm_fifo;
    localparam int unsigned AW    = 3;
    localparam int unsigned DEPTH = 1 << AW;
    localparam int unsigned AF    = 6;
    localparam int unsigned AE    = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr = 1'b0, rd = 1'b0;
    logic [31:0] wd = '0;

    logic        bp_wwait, bp_rwait, bp_af, bp_ae;
    logic [31:0] bp_rdata;
    logic [AW:0] bp_fill;
    logic        nb_wwait, nb_rwait, nb_af, nb_ae;
    logic [31:0] nb_rdata;
    logic [AW:0] nb_fill;

    int unsigned vectors = 0, miscompares = 0;

    logic [31:0] q_bp[$], q_nb[$];
    logic [31:0] last_bp = '0, last_nb = '0;

    always #2 clk = ~clk;

    mm_fifo #(.DEPTH_LOG2(AW), .BACKPRESSURE(1'b1), .STATUS_EN(1'b1),
              .AF_LEVEL(AF), .AE_LEVEL(AE)) i_mm_fifo (
        .clk(clk), .rst(rst), .wr_write(wr), .wr_writedata(wd),
        .wr_waitrequest(bp_wwait), .rd_read(rd), .rd_readdata(bp_rdata),
        .rd_waitrequest(bp_rwait), .fill_level(bp_fill),
        .almost_full(bp_af), .almost_empty(bp_ae));

    mm_fifo #(.DEPTH_LOG2(AW), .BACKPRESSURE(1'b0), .STATUS_EN(1'b0),
              .AF_LEVEL(AF), .AE_LEVEL(AE)) i_mm_fifo_nobp (
        .clk(clk), .rst(rst), .wr_write(wr), .wr_writedata(wd),
        .wr_waitrequest(nb_wwait), .rd_read(rd), .rd_readdata(nb_rdata),
        .rd_waitrequest(nb_rwait), .fill_level(nb_fill),
        .almost_full(nb_af), .almost_empty(nb_ae));

    task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s %s: got %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // Compare every output against the queue models, then advance the models
    task automatic cmp_all();
        int  n;
        logic ew, er, wok, rok;
        logic [31:0] ed;
        n  = q_bp.size();
        ew = (n == DEPTH);
        er = (n == 0);
        ed = er ? last_bp : q_bp[0];
        chk("R2", "bp wr_waitrequest", 64'(bp_wwait), 64'(ew));
        chk("R3", "bp rd_waitrequest", 64'(bp_rwait), 64'(er));
        chk("R1/R4", "bp rd_readdata", 64'(bp_rdata), 64'(ed));
        chk("R7", "bp fill_level", 64'(bp_fill), 64'(n));
        chk("R8", "bp almost_full", 64'(bp_af), 64'(n >= AF));
        chk("R8", "bp almost_empty", 64'(bp_ae), 64'(n <= AE));
        wok = wr && !ew;
        rok = rd && !er;
        if (rok) last_bp = q_bp.pop_front();
        if (wok) q_bp.push_back(wd);

        n  = q_nb.size();
        ed = (n == 0) ? last_nb : q_nb[0];
        chk("R9", "nobp wr_waitrequest", 64'(nb_wwait), 64'd0);
        chk("R9", "nobp rd_waitrequest", 64'(nb_rwait), 64'd0);
        chk("R9", "nobp rd_readdata", 64'(nb_rdata), 64'(ed));
        chk("R11", "nobp status", {61'd0, nb_fill == '0 ? 1'b0 : 1'b1, nb_af, nb_ae}, 64'd0);
        wok = wr && (n < DEPTH);
        rok = rd && (n > 0);
        if (rok) last_nb = q_nb.pop_front();
        if (wok) q_nb.push_back(wd);
    endtask

    task automatic drive(logic w, logic [31:0] d, logic r);
        @(negedge clk);
        wr = w; wd = d; rd = r;
        #1;
    endtask

    task automatic step(logic w, logic [31:0] d, logic r);
        drive(w, d, r);
        cmp_all();
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin : main
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R10: reset state
        chk("R10", "fill after reset", 64'(bp_fill), 64'd0);
        chk("R10", "readdata after reset", 64'(bp_rdata), 64'd0);
        chk("R10", "rd_waitrequest after reset", 64'(bp_rwait), 64'd1);

        // Read on empty: stalls in one instance, returns 0 in the other (R3, R9)
        step(1'b0, 32'h0, 1'b1);
        step(1'b0, 32'h0, 1'b1);

        // Fill past full (R1, R2, R9 drop)
        for (int i = 0; i < DEPTH + 3; i++) step(1'b1, 32'hA000_0000 + 32'(i), 1'b0);

        // R5: read and write together at full
        drive(1'b1, 32'hBEEF_0001, 1'b1);
        chk("R5", "write stalls at full", 64'(bp_wwait), 64'd1);
        cmp_all();
        drive(1'b1, 32'hBEEF_0001, 1'b0);
        chk("R5", "write released next cycle", 64'(bp_wwait), 64'd0);
        cmp_all();
        drive(1'b0, 32'h0, 1'b0);
        chk("R5", "level back at depth", 64'(bp_fill), 64'(DEPTH));
        cmp_all();

        // Drain past empty (R4, R9 hold)
        for (int i = 0; i < DEPTH + 3; i++) step(1'b0, 32'h0, 1'b1);

        // R6: read and write together at empty
        drive(1'b1, 32'hC0DE_0006, 1'b1);
        chk("R6", "read stalls at empty", 64'(bp_rwait), 64'd1);
        cmp_all();
        drive(1'b0, 32'h0, 1'b1);
        chk("R6", "read returns written word", 64'(bp_rdata), 64'hC0DE_0006);
        cmp_all();

        // Mixed traffic with shifting bias
        for (int ph = 0; ph < 4; ph++) begin
            for (int i = 0; i < 300; i++) begin
                int pw, pr;
                pw = (ph == 0) ? 80 : (ph == 1) ? 30 : 55;
                pr = (ph == 0) ? 30 : (ph == 1) ? 80 : 55;
                step(($urandom % 100) < pw, $urandom, ($urandom % 100) < pr);
            end
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule